// File: doc/BRIEF.md
# Bus DMA Requester with Stall Watchdog

This block requests a DMA channel on a shared, arbitrated system bus for a slave device such as an audio card. It pulls the shared request line low, waits for arbitration to finish in its favour, and then holds the burst line for the whole grant. During the grant it watches the active-low status lines, the command strobe and the shared request line. When the transfer completes it releases the bus. When another agent requests the bus, it lets go within a few cycles.

The central arbiter only closes a transfer once both status lines, burst and command are all inactive. If the system DMA engine has masked the channel, no command strobe ever arrives and the bus is never closed. The built-in watchdog handles this case. It counts 14.318 MHz cycles of the grant, restarting at every command strobe. When it is about to saturate, it pulls status line S1 low for a short pulse that looks like an aborted cycle. The arbiter then ends the transfer. The block backs off and requests again once an idle arbitration period has passed. An optional escalation variant widens the S1 pulse and also pulls the command strobe low.

All bus inputs are asynchronous and are resynchronised into the local clock domain. The outputs are open-drain pull enables: 1 pulls the line low and 0 leaves it high-impedance.

Top module: `dma_stall_requester`

## Requirements
- R1: After reset all pull enables (request, burst, S1, command) are 0 and `granted_o` is 0.
- R2: With `dreq_i` high and no grant held, the block drives `req_pull_o` = 1 within two cycles. It never drives request and burst together.
- R3: While requesting, once the synchronised arbitration line reads low (grant phase) with `arb_win_i` high, the block enters the granted state: `granted_o` = 1, `burst_pull_o` = 1, `req_pull_o` = 0.
- R4: While granted and past the entry blanking, a low on `preempt_n_i` drops `burst_pull_o` and `granted_o` on the third clock edge after the change. This is far inside the 7.8 µs (112-cycle) limit.
- R5: After a preemption the block does not request again until `preempt_n_i` reads high and the arbitration line reads high (an arbitration period). It then re-requests if `dreq_i` is still high.
- R6: With no command strobe during a grant, `s1_pull_o` rises at grant cycle 62 and stays high for exactly 2 cycles (about 140 ns, at least 85 ns). The count saturates and never wraps, so only one pulse is sent per grant.
- R7: Each synchronised low on `cmd_n_i` during a grant restarts the watchdog count. A transfer with strobes every 20 cycles therefore never produces an S1 pulse.
- R8: `s1_pull_o` and `cmd_pull_o` are only ever 1 while `granted_o` is 1.
- R9: After a watchdog recovery the block leaves the grant on cycle 64. It then drives neither request nor burst until an arbitration period is seen, and re-requests afterwards if `dreq_i` is still high.
- R10: When `dreq_i` falls while granted and S0, S1 and command read high, the block releases burst and returns to idle without any S1 pulse.
- R11: With `ESCALATE`=1, `s1_pull_o` is high for grant cycles 58 to 63 (6 cycles). `cmd_pull_o` is high for grant cycles 60 to 63 (4 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 14.318 MHz local clock |
| rst_n | input | 1 | Active-low reset |
| dreq_i | input | 1 | Local DMA request pending (synchronous) |
| arb_win_i | input | 1 | Our priority level won arbitration (async) |
| arb_gnt_i | input | 1 | Bus arbitration line: 1 = arbitration period, 0 = grant phase (async) |
| preempt_n_i | input | 1 | Shared active-low request/preempt line as sensed (async) |
| cmd_n_i | input | 1 | Active-low command strobe as sensed (async) |
| s0_n_i | input | 1 | Active-low status S0 as sensed (async) |
| s1_n_i | input | 1 | Active-low status S1 as sensed (async) |
| req_pull_o | output | 1 | Pull shared request line low |
| burst_pull_o | output | 1 | Pull burst line low |
| s1_pull_o | output | 1 | Pull S1 low (watchdog recovery) |
| cmd_pull_o | output | 1 | Pull command strobe low (escalation only) |
| granted_o | output | 1 | Block currently holds the grant |

## Verification
The bench measures the preemption release latency to the exact cycle. A design that ignored preemption would keep burst held and fail the count. A design that re-requested at once would show a request while the line is still held. The watchdog pulse is timed by its first cycle and its width, for both the plain and the escalation variants. A wrapping counter would show a second pulse, and a pulse of one cycle would fall short of the 85 ns minimum. A healthy transfer with regular strobes is run well beyond the firing point to catch a counter that ignores command strobes. After recovery, the bench checks that no request appears before an arbitration period.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_OWN  = 2'd2,
      ST_WAIT = 2'd3
   } rq_state_t;

   // order of bits in the synchronised input vector
   localparam int SI_S1   = 0;
   localparam int SI_S0   = 1;
   localparam int SI_CMD  = 2;
   localparam int SI_PRE  = 3;
   localparam int SI_GNT  = 4;
   localparam int SI_WIN  = 5;
   localparam int SI_W    = 6;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
   parameter int                 WIDTH   = 6,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsr_watchdog.sv
module dsr_watchdog #(
   parameter int CNT_W    = 6,
   parameter bit ESCALATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,       // grant held
   input  logic cmd_seen_i,  // synchronised command strobe active
   output logic s1_pull_o,
   output logic cmd_pull_o,
   output logic expired_o
);
   localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] FIRE_AT   = CNT_MAX - 1'b1;
   localparam logic [CNT_W-1:0] ESC_S1_AT = CNT_MAX - 3'd5;
   localparam logic [CNT_W-1:0] ESC_CM_AT = CNT_MAX - 3'd3;

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("dsr_watchdog: CNT_W must be at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             restart;

   // a strobe we drive ourselves must not restart the count
   assign restart = cmd_seen_i && !cmd_pull_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || restart) cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == CNT_MAX);

   generate
      if (ESCALATE) begin : g_escalate
         assign s1_pull_o  = run_i && (cnt_q >= ESC_S1_AT);
         assign cmd_pull_o = run_i && (cnt_q >= ESC_CM_AT);
      end else begin : g_plain
         assign s1_pull_o  = run_i && (cnt_q >= FIRE_AT);
         assign cmd_pull_o = 1'b0;
      end
   endgenerate

   // R6: count saturates, it never wraps back while the grant lasts
   a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/dsr_fsm.sv
module dsr_fsm
   import dsr_pkg::*;
#(
   parameter int BLANK = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dreq_i,
   input  logic win_s_i,
   input  logic gnt_s_i,
   input  logic pre_n_s_i,
   input  logic bus_idle_i,
   input  logic wd_expired_i,
   output logic req_pull_o,
   output logic burst_pull_o,
   output logic granted_o
);
   localparam int BW = $clog2(BLANK + 2);

   rq_state_t st_q, st_d;
   logic [BW-1:0] blank_q;
   logic          blanked;

   assign blanked = (blank_q != '0);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (dreq_i) st_d = ST_REQ;
         ST_REQ: begin
            if (!dreq_i)                   st_d = ST_IDLE;
            else if (!gnt_s_i && win_s_i)  st_d = ST_OWN;
         end
         ST_OWN: begin
            if (!pre_n_s_i && !blanked)    st_d = ST_WAIT;
            else if (wd_expired_i)         st_d = ST_WAIT;
            else if (!dreq_i && bus_idle_i) st_d = ST_IDLE;
         end
         ST_WAIT: if (pre_n_s_i && gnt_s_i) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         blank_q <= '0;
      end else begin
         st_q <= st_d;
         // our own request echo still sits in the synchroniser at grant entry
         if (st_q != ST_OWN && st_d == ST_OWN) blank_q <= BW'(BLANK);
         else if (blanked)                     blank_q <= blank_q - 1'b1;
      end
   end

   assign req_pull_o   = (st_q == ST_REQ);
   assign burst_pull_o = (st_q == ST_OWN);
   assign granted_o    = (st_q == ST_OWN);

   // R2: request and burst never driven together
   a_r2_req_burst_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_pull_o && burst_pull_o));
   // R4: sensed preempt past blanking releases burst on the next edge
   a_r4_preempt_release: assert property (@(posedge clk) disable iff (!rst_n)
      (granted_o && !pre_n_s_i && !blanked) |=> !burst_pull_o);
   // R9: expiry leaves the grant and drives nothing
   a_r9_drop_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      wd_expired_i |=> (!req_pull_o && !burst_pull_o));
endmodule

// File: rtl/dma_stall_requester.sv
module dma_stall_requester
   import dsr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 6,
   parameter bit ESCALATE    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dreq_i,
   input  logic arb_win_i,
   input  logic arb_gnt_i,
   input  logic preempt_n_i,
   input  logic cmd_n_i,
   input  logic s0_n_i,
   input  logic s1_n_i,
   output logic req_pull_o,
   output logic burst_pull_o,
   output logic s1_pull_o,
   output logic cmd_pull_o,
   output logic granted_o
);
   localparam logic [SI_W-1:0] SYNC_RST = 6'b01_1111;

   logic [SI_W-1:0] raw, syn;
   logic            bus_idle, expired, wd_s1, wd_cmd;

   assign raw = {arb_win_i, arb_gnt_i, preempt_n_i, cmd_n_i, s0_n_i, s1_n_i};

   dsr_sync #(.WIDTH(SI_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
   );

   assign bus_idle = syn[SI_S0] && syn[SI_S1] && syn[SI_CMD];

   dsr_watchdog #(.CNT_W(CNT_W), .ESCALATE(ESCALATE)) u_wd (
      .clk(clk), .rst_n(rst_n), .run_i(granted_o), .cmd_seen_i(!syn[SI_CMD]),
      .s1_pull_o(wd_s1), .cmd_pull_o(wd_cmd), .expired_o(expired)
   );

   dsr_fsm #(.BLANK(SYNC_STAGES + 1)) u_fsm (
      .clk(clk), .rst_n(rst_n), .dreq_i(dreq_i),
      .win_s_i(syn[SI_WIN]), .gnt_s_i(syn[SI_GNT]), .pre_n_s_i(syn[SI_PRE]),
      .bus_idle_i(bus_idle), .wd_expired_i(expired),
      .req_pull_o(req_pull_o), .burst_pull_o(burst_pull_o), .granted_o(granted_o)
   );

   // forced pulses only while the arbitration is ours
   assign s1_pull_o  = wd_s1  && granted_o;
   assign cmd_pull_o = wd_cmd && granted_o;

   // R8: forced lines only while granted
   a_r8_pull_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_pull_o || cmd_pull_o) |-> granted_o);
   // R6: the S1 pulse is never shorter than two cycles
   a_r6_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(s1_pull_o) |-> $past(s1_pull_o, 2));
endmodule

// File: tb/dma_stall_requester_tb.sv
`timescale 1ns/1ps
module dma_stall_requester_tb;
   localparam real CLK_P = 70.0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic dreq = 0, win = 0, gnt = 1, ext_pre = 0, cmd_n = 1, s0_n = 1, s1_n = 1;
   logic req_a, burst_a, s1p_a, cmdp_a, gr_a;
   logic req_b, burst_b, s1p_b, cmdp_b, gr_b;
   logic pre_n;
   int   n_chk = 0, n_fail = 0;
   bit   done = 0;

   always #(CLK_P/2) clk = ~clk;

   assign pre_n = !(req_a || req_b || ext_pre);

   dma_stall_requester u_dut (
      .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .arb_win_i(win), .arb_gnt_i(gnt),
      .preempt_n_i(pre_n), .cmd_n_i(cmd_n), .s0_n_i(s0_n), .s1_n_i(s1_n),
      .req_pull_o(req_a), .burst_pull_o(burst_a), .s1_pull_o(s1p_a),
      .cmd_pull_o(cmdp_a), .granted_o(gr_a));

   dma_stall_requester #(.ESCALATE(1'b1)) u_esc (
      .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .arb_win_i(win), .arb_gnt_i(gnt),
      .preempt_n_i(pre_n), .cmd_n_i(cmd_n), .s0_n_i(s0_n), .s1_n_i(s1_n),
      .req_pull_o(req_b), .burst_pull_o(burst_b), .s1_pull_o(s1p_b),
      .cmd_pull_o(cmdp_b), .granted_o(gr_b));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; dreq = 0; win = 0; gnt = 1; ext_pre = 0; cmd_n = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   // request then grant; returns at the negedge where granted_o is first seen
   task automatic get_grant(output bit ok);
      ok = 0;
      dreq = 1;
      for (int i = 0; i < 10 && !req_a; i++) @(negedge clk);
      gnt = 0; win = 1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (gr_a) begin ok = 1; break; end
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk(!req_a && !burst_a && !s1p_a && !cmdp_a && !gr_a, "R1",
          {req_a, burst_a, s1p_a, cmdp_a, gr_a}, 0);
   endtask

   task automatic t_request_and_done();
      bit ok;
      int lat;
      do_reset();
      dreq = 1;
      lat = 0;
      while (!req_a && lat < 5) begin @(negedge clk); lat++; end
      chk(req_a && lat <= 2, "R2", lat, 2);
      get_grant(ok);
      chk(ok && burst_a && !req_a, "R3", {ok, burst_a, req_a}, 3'b110);
      // healthy burst: command strobe every 20 cycles (R7)
      begin
         int pulses = 0;
         for (int i = 1; i <= 200; i++) begin
            cmd_n = (i % 20 == 0) ? 1'b0 : 1'b1;
            @(negedge clk);
            if (s1p_a) pulses++;
         end
         cmd_n = 1;
         chk(pulses == 0 && gr_a, "R7", pulses, 0);
      end
      dreq = 0;
      repeat (5) @(negedge clk);
      chk(!gr_a && !burst_a && !req_a && !s1p_a, "R10", {gr_a, burst_a, req_a}, 0);
      gnt = 1; win = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_preempt();
      bit ok;
      int lat;
      do_reset();
      get_grant(ok);
      repeat (10) @(negedge clk);
      ext_pre = 1;
      lat = 0;
      while (burst_a && lat < 10) begin @(negedge clk); lat++; end
      chk(!burst_a && !gr_a && lat == 3, "R4", lat, 3);
      begin
         int reqs = 0;
         for (int i = 0; i < 10; i++) begin @(negedge clk); if (req_a) reqs++; end
         ext_pre = 0;
         for (int i = 0; i < 8; i++) begin @(negedge clk); if (req_a) reqs++; end
         chk(reqs == 0, "R5", reqs, 0);
      end
      gnt = 1; win = 0;
      lat = 0;
      while (!req_a && lat < 10) begin @(negedge clk); lat++; end
      chk(req_a && lat <= 5, "R5", lat, 5);
   endtask

   task automatic t_watchdog();
      bit ok;
      int a_first = -1, a_width = 0, a_drop = -1, bad = 0;
      int b_s1_first = -1, b_s1_w = 0, b_cm_first = -1, b_cm_w = 0;
      do_reset();
      get_grant(ok);
      chk(ok && gr_b, "R3", {ok, gr_b}, 2'b11);
      for (int i = 0; i <= 80; i++) begin
         if (i > 0) @(negedge clk);
         if (s1p_a) begin if (a_first < 0) a_first = i; a_width++; end
         if (!gr_a && a_drop < 0) a_drop = i;
         if ((s1p_a || cmdp_a) && !gr_a) bad++;
         if ((s1p_b || cmdp_b) && !gr_b) bad++;
         if (s1p_b) begin if (b_s1_first < 0) b_s1_first = i; b_s1_w++; end
         if (cmdp_b) begin if (b_cm_first < 0) b_cm_first = i; b_cm_w++; end
      end
      chk(a_first == 62, "R6", a_first, 62);
      chk(a_width == 2, "R6", a_width, 2);
      chk(bad == 0 && !cmdp_a, "R8", bad, 0);
      chk(a_drop == 64, "R9", a_drop, 64);
      chk(!req_a && !burst_a, "R9", {req_a, burst_a}, 0);
      chk(b_s1_first == 58 && b_s1_w == 6, "R11", b_s1_first * 100 + b_s1_w, 5806);
      chk(b_cm_first == 60 && b_cm_w == 4, "R11", b_cm_first * 100 + b_cm_w, 6004);
      gnt = 1; win = 0;
      begin
         int lat = 0;
         while (!req_a && lat < 10) begin @(negedge clk); lat++; end
         chk(req_a && lat <= 5, "R9", lat, 5);
      end
   endtask

   initial begin
      t_reset();
      t_request_and_done();
      t_preempt();
      t_watchdog();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule